// File: doc/BRIEF.md
# Spare Tile Enable Allocator

This block settles, once at configuration time, which tiles of a tiled many-core die get their core pair switched on. Every tile holds a pair of cores that can only be turned on or off together. A fixed set of tile positions is held in reserve as spares. A spare is switched on only to stand in for an ordinary tile that is defective, so on a clean die the spares stay dark. The caller gives a per-tile defect mask and a requested core count, then pulses start.

The allocator walks the tiles one per clock in ascending order. For each tile it decides whether that tile is enabled, and it fills a table that maps each enabled slot to its physical tile. When the walk ends it reports the final enable mask, the number of cores that were enabled and a flag that says whether the die could not reach the request. A combinational lookup then turns a logical core number into the physical tile that carries it. With the default parameters there are 38 tiles of 2 cores, and the spares sit at positions 2, 8, 27 and 37.

Top module: `spare_tile_alloc`

## Requirements
- R1: After reset, busy, done, fail, core_valid and core_count are 0 and the tile enable mask is all zeros.
- R2: A start pulse sampled while idle or done sets busy on the next edge. Done rises exactly NUM_TILES clock edges after the edge that sampled start, and busy and done are never high together.
- R3: A non-spare tile is an ordinary tile. Each functional ordinary tile is enabled, up to the target. With a 68-core target and no defects, exactly the 34 ordinary tiles are enabled and the 4 spare tiles (bit positions 2, 8, 27, 37 of the mask) are off.
- R4: Spares are enabled only when the target tile count exceeds the number of functional ordinary tiles, one per missing tile. They are taken in ascending tile index, and defective spares are skipped.
- R5: When the target tile count is below the number of functional ordinary tiles, the surplus ordinary tiles with the highest indices stay disabled.
- R6: A tile whose defect bit is 1 is never enabled, whatever the target.
- R7: Fail is 1 at done exactly when the number of functional tiles (ordinary plus spare) is below the target tile count. In that case every functional tile is enabled. Otherwise the number of enabled tiles equals the target tile count.
- R8: core_count equals CORES_PER_TILE times the number of enabled tiles.
- R9: When done is high and core_sel / CORES_PER_TILE is below the number of enabled tiles, core_valid is 1 and core_tile gives the physical index of the enabled tile at that position, counting enabled tiles in ascending order from 0. Otherwise core_valid and core_tile are 0.
- R10: A start pulse while busy is ignored. The running allocation uses the inputs captured at its own start.
- R11: The target tile count is target_cores / CORES_PER_TILE rounded down, so an odd request of 69 behaves as 68.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins an allocation |
| defect_i | input | NUM_TILES | Per-tile defect flags, 1 = defective |
| target_cores_i | input | COREW | Requested number of cores |
| core_sel_i | input | COREW | Logical core number for the lookup |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Result valid, held until the next start |
| fail_o | output | 1 | Target could not be reached |
| tile_en_o | output | NUM_TILES | Tile enable mask |
| core_count_o | output | COREW | Number of enabled cores |
| core_valid_o | output | 1 | Lookup result valid |
| core_tile_o | output | TIDW | Physical tile of the selected core |

## Verification
The mask, count and fail result are due on the edge NUM_TILES cycles after the edge that samples start. The scoreboard stamps the start edge with a free-running cycle counter. It compares a queued expectation on the falling edge where done is first seen high, and it checks that the distance is exactly NUM_TILES. The lookup is combinational once done is high, so the driver changes core_sel on a falling edge and samples the result a nanosecond later, with no clock edge between. Inputs changed mid-scan test that the captured copies govern the result.

// File: rtl/sta_pkg.sv
package sta_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_DONE = 2'd2
   } scan_state_e;
endpackage

// File: rtl/sta_census.sv
// Counts the functional ordinary tiles and the functional spare tiles.
module sta_census #(
   parameter int unsigned NT = 38,
   parameter logic [NT-1:0] SPARE_MASK = '0,
   parameter int unsigned CNTW = 6
) (
   input  logic [NT-1:0]   defect_i,
   output logic [CNTW-1:0] ord_ok_o,
   output logic [CNTW-1:0] spare_ok_o
);
   always_comb begin
      ord_ok_o   = '0;
      spare_ok_o = '0;
      for (int i = 0; i < int'(NT); i++) begin
         if (!defect_i[i]) begin
            if (SPARE_MASK[i]) spare_ok_o = spare_ok_o + 1'b1;
            else               ord_ok_o   = ord_ok_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sta_scan.sv
// Sequential walker: decides one tile per clock.
module sta_scan
   import sta_pkg::*;
#(
   parameter int unsigned NT = 38,
   parameter int unsigned CPT = 2,
   parameter logic [NT-1:0] SPARE_MASK = '0,
   parameter int unsigned TIDW = 6,
   parameter int unsigned CNTW = 6,
   parameter int unsigned COREW = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NT-1:0]    defect_i,
   input  logic [COREW-1:0] target_cores_i,
   input  logic [CNTW-1:0]  ord_ok_i,
   input  logic [CNTW-1:0]  spare_ok_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [NT-1:0]    en_o,
   output logic             fail_o,
   output logic [CNTW-1:0]  slot_o,
   output logic [NT-1:0]    def_cap_o,
   output logic [COREW-1:0] tgt_cap_o,
   output logic             wr_en_o,
   output logic [TIDW-1:0]  wr_addr_o,
   output logic [TIDW-1:0]  wr_tile_o
);
   localparam logic [TIDW-1:0] LAST_IDX = TIDW'(NT - 1);

   scan_state_e      state_q;
   logic [TIDW-1:0]  idx_q;
   logic [NT-1:0]    def_q;
   logic [NT-1:0]    en_q;
   logic [COREW-1:0] tgt_q;
   logic [COREW-1:0] need_q;
   logic [CNTW-1:0]  ord_used_q;
   logic [CNTW-1:0]  sp_used_q;
   logic [CNTW-1:0]  slot_q;
   logic             fail_q;

   logic [COREW-1:0] tgt_in;
   logic [COREW-1:0] ord_ext;
   logic [COREW:0]   ok_sum;
   logic             accept;
   logic             cur_ok;
   logic             cur_sp;
   logic             take;

   assign tgt_in  = COREW'(target_cores_i / COREW'(CPT));
   assign ord_ext = COREW'(ord_ok_i);
   assign ok_sum  = (COREW + 1)'(ord_ok_i) + (COREW + 1)'(spare_ok_i);
   assign accept  = start_i && (state_q != ST_SCAN);

   assign cur_ok = !def_q[idx_q];
   assign cur_sp = SPARE_MASK[idx_q];
   assign take   = (state_q == ST_SCAN) && cur_ok &&
                   (cur_sp ? (COREW'(sp_used_q) < need_q)
                           : (COREW'(ord_used_q) < tgt_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         def_q      <= '0;
         en_q       <= '0;
         tgt_q      <= '0;
         need_q     <= '0;
         ord_used_q <= '0;
         sp_used_q  <= '0;
         slot_q     <= '0;
         fail_q     <= 1'b0;
      end else if (accept) begin
         state_q    <= ST_SCAN;
         idx_q      <= '0;
         def_q      <= defect_i;
         en_q       <= '0;
         tgt_q      <= tgt_in;
         need_q     <= (tgt_in > ord_ext) ? (tgt_in - ord_ext) : '0;
         ord_used_q <= '0;
         sp_used_q  <= '0;
         slot_q     <= '0;
         fail_q     <= ok_sum < {1'b0, tgt_in};
      end else if (state_q == ST_SCAN) begin
         if (take) begin
            en_q[idx_q] <= 1'b1;
            slot_q      <= slot_q + 1'b1;
            if (cur_sp) sp_used_q  <= sp_used_q + 1'b1;
            else        ord_used_q <= ord_used_q + 1'b1;
         end
         if (idx_q == LAST_IDX) state_q <= ST_DONE;
         else                   idx_q   <= idx_q + 1'b1;
      end
   end

   assign busy_o    = (state_q == ST_SCAN);
   assign done_o    = (state_q == ST_DONE);
   assign en_o      = en_q;
   assign fail_o    = fail_q && (state_q == ST_DONE);
   assign slot_o    = slot_q;
   assign def_cap_o = def_q;
   assign tgt_cap_o = tgt_q;
   assign wr_en_o   = take;
   assign wr_addr_o = TIDW'(slot_q);
   assign wr_tile_o = idx_q;
endmodule

// File: rtl/sta_map.sv
// Slot-to-tile table filled during the scan.
module sta_map #(
   parameter int unsigned NT = 38,
   parameter int unsigned TIDW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic [TIDW-1:0] wr_addr_i,
   input  logic [TIDW-1:0] wr_tile_i,
   input  logic [TIDW-1:0] rd_addr_i,
   output logic [TIDW-1:0] rd_tile_o
);
   logic [TIDW-1:0] ent [NT];

   for (genvar g = 0; g < int'(NT); g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   ent[g] <= '0;
         else if (wr_en_i && wr_addr_i == TIDW'(g))    ent[g] <= wr_tile_i;
      end
   end

   always_comb begin
      rd_tile_o = '0;
      for (int i = 0; i < int'(NT); i++)
         if (rd_addr_i == TIDW'(i)) rd_tile_o = ent[i];
   end
endmodule

// File: rtl/spare_tile_alloc.sv
module spare_tile_alloc #(
   parameter int unsigned NUM_TILES = 38,
   parameter int unsigned CORES_PER_TILE = 2,
   parameter logic [NUM_TILES-1:0] SPARE_MASK = 38'h20_0800_0104,
   localparam int unsigned TIDW  = $clog2(NUM_TILES),
   localparam int unsigned CNTW  = $clog2(NUM_TILES + 1),
   localparam int unsigned COREW = $clog2(NUM_TILES * CORES_PER_TILE + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [NUM_TILES-1:0] defect_i,
   input  logic [COREW-1:0]     target_cores_i,
   input  logic [COREW-1:0]     core_sel_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 fail_o,
   output logic [NUM_TILES-1:0] tile_en_o,
   output logic [COREW-1:0]     core_count_o,
   output logic                 core_valid_o,
   output logic [TIDW-1:0]      core_tile_o
);
   if (NUM_TILES < 2) begin : g_bad_tiles
      $error("NUM_TILES must be at least 2");
   end
   if (CORES_PER_TILE < 1) begin : g_bad_cpt
      $error("CORES_PER_TILE must be at least 1");
   end
   if (SPARE_MASK == '1) begin : g_bad_mask
      $error("at least one ordinary tile is required");
   end

   logic [CNTW-1:0]      ord_ok;
   logic [CNTW-1:0]      spare_ok;
   logic [CNTW-1:0]      slot;
   logic [NUM_TILES-1:0] def_cap;
   logic [COREW-1:0]     tgt_cap;
   logic                 wr_en;
   logic [TIDW-1:0]      wr_addr;
   logic [TIDW-1:0]      wr_tile;
   logic [COREW-1:0]     sel_tile;
   logic [TIDW-1:0]      rd_tile;

   sta_census #(.NT(NUM_TILES), .SPARE_MASK(SPARE_MASK), .CNTW(CNTW)) u_census (
      .defect_i  (defect_i),
      .ord_ok_o  (ord_ok),
      .spare_ok_o(spare_ok)
   );

   sta_scan #(
      .NT(NUM_TILES), .CPT(CORES_PER_TILE), .SPARE_MASK(SPARE_MASK),
      .TIDW(TIDW), .CNTW(CNTW), .COREW(COREW)
   ) u_scan (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .defect_i      (defect_i),
      .target_cores_i(target_cores_i),
      .ord_ok_i      (ord_ok),
      .spare_ok_i    (spare_ok),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .en_o          (tile_en_o),
      .fail_o        (fail_o),
      .slot_o        (slot),
      .def_cap_o     (def_cap),
      .tgt_cap_o     (tgt_cap),
      .wr_en_o       (wr_en),
      .wr_addr_o     (wr_addr),
      .wr_tile_o     (wr_tile)
   );

   sta_map #(.NT(NUM_TILES), .TIDW(TIDW)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en),
      .wr_addr_i(wr_addr),
      .wr_tile_i(wr_tile),
      .rd_addr_i(TIDW'(sel_tile)),
      .rd_tile_o(rd_tile)
   );

   assign sel_tile     = COREW'(core_sel_i / COREW'(CORES_PER_TILE));
   assign core_valid_o = done_o && (sel_tile < COREW'(slot));
   assign core_tile_o  = core_valid_o ? rd_tile : '0;
   assign core_count_o = COREW'(slot * CORES_PER_TILE);
endmodule

// File: rtl/sta_checker.sv
module sta_checker #(
   parameter int unsigned NT = 38,
   parameter int unsigned CPT = 2,
   parameter int unsigned TIDW = 6,
   parameter int unsigned COREW = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             fail_o,
   input logic [NT-1:0]    tile_en_o,
   input logic [COREW-1:0] core_count_o,
   input logic             core_valid_o,
   input logic [TIDW-1:0]  core_tile_o,
   input logic [NT-1:0]    def_cap,
   input logic [COREW-1:0] tgt_cap
);
   logic [TIDW:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= '0;
      else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
      else             busy_cnt <= '0;
   end

   assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   assert_scan_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (int'(busy_cnt) == int'(NT)) && done_o);

   assert_no_defective_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tile_en_o & def_cap) == '0);

   assert_core_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(core_count_o) == int'(CPT) * $countones(tile_en_o));

   assert_fail_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fail_o) |-> int'(core_count_o) < int'(tgt_cap) * int'(CPT));

   assert_exact_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fail_o) |-> $countones(tile_en_o) == int'(tgt_cap));

   assert_lookup_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_valid_o |-> (tile_en_o >> core_tile_o) & NT'(1)) ;

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(def_cap) && $stable(tgt_cap));
endmodule

bind spare_tile_alloc sta_checker #(
   .NT(NUM_TILES), .CPT(CORES_PER_TILE), .TIDW(TIDW), .COREW(COREW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .fail_o      (fail_o),
   .tile_en_o   (tile_en_o),
   .core_count_o(core_count_o),
   .core_valid_o(core_valid_o),
   .core_tile_o (core_tile_o),
   .def_cap     (def_cap),
   .tgt_cap     (tgt_cap)
);

// File: tb/sim_spare_tile_alloc.sv
`timescale 1ns/1ps
module sim_spare_tile_alloc;
   localparam int NT = 38;
   localparam logic [NT-1:0] SP = 38'h20_0800_0104;

   typedef struct {
      logic [NT-1:0] mask;
      int            cores;
      logic          fail;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [NT-1:0] defect_i = '0;
   logic [6:0]    target_cores_i = '0;
   logic [6:0]    core_sel_i = '0;
   logic          busy_o, done_o, fail_o, core_valid_o;
   logic [NT-1:0] tile_en_o;
   logic [6:0]    core_count_o;
   logic [5:0]    core_tile_o;

   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;
   int   st_cyc = 0;
   bit   timeout = 0;
   exp_t q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spare_tile_alloc u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .defect_i(defect_i),
      .target_cores_i(target_cores_i), .core_sel_i(core_sel_i),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .tile_en_o(tile_en_o),
      .core_count_o(core_count_o), .core_valid_o(core_valid_o),
      .core_tile_o(core_tile_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Reference allocation from the requirements (R3 R4 R5 R6 R7 R11).
   function automatic exp_t model(input logic [NT-1:0] d, input int tc);
      exp_t e;
      int tgt = tc / 2;
      int ford = 0, fsp = 0, need, ou = 0, su = 0, n = 0;
      for (int i = 0; i < NT; i++)
         if (!d[i]) begin
            if (SP[i]) fsp++; else ford++;
         end
      need = (tgt > ford) ? tgt - ford : 0;
      e.mask = '0;
      for (int i = 0; i < NT; i++) begin
         if (!d[i] && !SP[i] && ou < tgt) begin e.mask[i] = 1'b1; ou++; n++; end
         if (!d[i] && SP[i] && su < need) begin e.mask[i] = 1'b1; su++; n++; end
      end
      e.cores = 2 * n;
      e.fail  = (ford + fsp) < tgt;
      return e;
   endfunction

   function automatic int nth_tile(input logic [NT-1:0] m, input int k);
      int c = 0;
      for (int i = 0; i < NT; i++)
         if (m[i]) begin
            if (c == k) return i;
            c++;
         end
      return 0;
   endfunction

   // Monitor: compares the result where done first appears.
   initial begin
      bit prev = 0;
      forever begin
         @(negedge clk);
         if (done_o && !prev) begin
            exp_t e;
            if (q.size() == 0) chk(0, "R2 unexpected done", 1, 0);
            else begin
               e = q.pop_front();
               chk(cyc - st_cyc == NT, "R2 done latency", cyc - st_cyc, NT);
               chk(tile_en_o == e.mask, "R3/R4/R5/R6 mask", tile_en_o, e.mask);
               chk(int'(core_count_o) == e.cores, "R8 core count", core_count_o, e.cores);
               chk(fail_o == e.fail, "R7 fail flag", fail_o, e.fail);
            end
         end
         prev = done_o;
      end
   end

   task automatic lookup(input logic [NT-1:0] m, input int cores, input int k);
      @(negedge clk);
      core_sel_i = 7'(k);
      #1;
      if (k / 2 < cores / 2) begin
         chk(core_valid_o == 1'b1, "R9 lookup valid", core_valid_o, 1);
         chk(int'(core_tile_o) == nth_tile(m, k / 2), "R9 lookup tile",
             core_tile_o, nth_tile(m, k / 2));
      end else begin
         chk(core_valid_o == 1'b0 && core_tile_o == '0, "R9 lookup out of range",
             {core_valid_o, core_tile_o}, 0);
      end
   endtask

   task automatic run_case(input logic [NT-1:0] d, input int tc, input bit poke);
      exp_t e = model(d, tc);
      q.push_back(e);
      @(negedge clk);
      defect_i = d;
      target_cores_i = 7'(tc);
      start_i = 1'b1;
      @(negedge clk);
      st_cyc = cyc;
      start_i = 1'b0;
      if (poke) begin
         // R10: a second start while busy must be ignored
         repeat (5) @(negedge clk);
         chk(busy_o == 1'b1, "R2 busy during scan", busy_o, 1);
         defect_i = ~d;
         target_cores_i = 7'd2;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (!done_o) @(negedge clk);
      #1;
      chk(busy_o == 1'b0, "R2 busy clear at done", busy_o, 0);
      lookup(e.mask, e.cores, 0);
      lookup(e.mask, e.cores, 25);
      lookup(e.mask, e.cores, e.cores - 1);
      lookup(e.mask, e.cores, e.cores);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            chk(busy_o == 0 && done_o == 0 && fail_o == 0 && tile_en_o == '0 &&
                core_count_o == '0 && core_valid_o == 0, "R1 reset state",
                {busy_o, done_o, fail_o, core_valid_o, core_count_o}, 0);
            rst_n = 1'b1;
            run_case('0, 68, 0);                                 // R3 clean die
            run_case(38'h20, 68, 0);                             // R4 one defect -> tile 2
            run_case(38'h424, 68, 0);                            // R4 R6 spare 2 bad -> 8, 27
            run_case('0, 64, 0);                                 // R5 top ordinaries off
            run_case('0, 72, 0);                                 // R4 two spares
            run_case(38'h0800_003F, 72, 0);                      // R7 fail
            run_case('0, 69, 0);                                 // R11 odd request
            run_case(38'h1, 64, 1);                              // R10 R5 R6
            run_case(38'h3000_0000, 76, 0);                      // R7 full request
         end
         begin
            repeat (200000) @(posedge clk);
            timeout = 1;
         end
      join_any
      if (timeout) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule